// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

The block holds two 8-bit up-counters, a low channel and a high channel, each paired with its own 8-bit compare register. With the cascade bit at 0 the two channels run as independent interval timers driven by the same selected tick. With the cascade bit at 1 they form one 16-bit interval timer. The low counter counts the selected tick, and its wrap from 0xFF to 0x00 is the only event that advances the high counter.

In cascade mode the low channel keeps its own behaviour: every low-byte match still pulses the low interrupt and flips the low toggle output. The 16-bit terminal event needs both bytes to match at the same time. The count tick is taken from a bank of prescaled strobes, picked by a 4-bit select field. The full 16-bit count is always presented as one registered word.

Top module: `dual_timer_cascade`

## Requirements
- R1: After a synchronous reset both counters, both compare registers, both interrupt outputs and the toggle output are 0.
- R2: Select value k in 0..4 uses strobe bit k (the strobes divide the clock by 2, 4, 8, 16 and 32, in that order). Any select value of 5 or above gives no tick, so the count does not change.
- R3: While the enable bit is 0 both counters hold their value and no interrupt pulses.
- R4: In cascade mode the low counter increments on each tick. When it wraps from 0xFF to 0x00, the high counter increments on the same clock edge. The count output carries the high byte in bits 15:8 and the low byte in bits 7:0.
- R5: In cascade mode, a tick on which the low count equals the low compare value and the high count equals the high compare value clears both counters and pulses the high interrupt for one cycle. With compare value N, the pulses repeat every N+1 ticks.
- R6: In both modes, a tick on which the low count equals the low compare value pulses the low interrupt for one cycle and inverts the toggle output.
- R7: On the first cycle with the enable bit at 1 after a cycle with it at 0, both counters clear to 0 and no counting happens in that cycle.
- R8: In independent mode each counter increments on the selected tick. A counter that matches its own compare value on a tick clears to 0. A high-counter match pulses the high interrupt.
- R9: A compare register write lands on the next clock edge and applies from the following tick. It never clears the counters.
- R10: Every output is registered and updates on the clock edge after the tick that causes it. The 16-bit count comes from a single register bank, so both of its bytes always belong to the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| strobes_i | input | 5 | Prescaled tick strobes, divide-by-2 to divide-by-32 |
| clk_sel_i | input | 4 | Tick source select |
| enable_i | input | 1 | Count enable |
| cascade_i | input | 1 | 1 = one 16-bit timer, 0 = two 8-bit timers |
| cmp_lo_we_i | input | 1 | Write strobe for the low compare register |
| cmp_hi_we_i | input | 1 | Write strobe for the high compare register |
| cmp_wdata_i | input | 8 | Write data for the compare registers |
| irq_lo_o | output | 1 | Low-channel match pulse |
| irq_hi_o | output | 1 | High-channel or 16-bit match pulse |
| tog_lo_o | output | 1 | Low-channel toggle output |
| count_o | output | 16 | Coherent count word {high, low} |

## Verification
The bench runs the 16-bit timer with a small compare value, which separates clearing on the full 16-bit match from clearing on a low-byte match alone. A compare value above 0xFF forces the low counter to wrap, which exposes a wrong carry into the high counter. A compare value of zero checks that a match on every tick is handled. Independent mode is run with unequal compare bytes, so any crosstalk between the channels shows. Separate runs use fast and slow strobes, an invalid select value, enable held low, enable restarted, and a compare write while the count is frozen. Together these tell the tick routing, the hold, the restart clear and the no-clear rule on writes apart from the counting itself.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int unsigned DT_BYTE_W = 8;
  localparam int unsigned DT_SEL_W  = 4;
  localparam int unsigned DT_NSRC   = 5;

  typedef struct packed {
    logic clr;
    logic inc;
  } dt_ctl_t;
endpackage

// File: rtl/dtimer_tick_sel.sv
module dtimer_tick_sel #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned NSRC  = 5
) (
  input  logic [NSRC-1:0]  strobes_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_i == SEL_W'(i)) tick_o = strobes_i[i];
    end
  end
endmodule

// File: rtl/dtimer_cmp_reg.sv
module dtimer_cmp_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)     q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/dtimer_chan.sv
module dtimer_chan
  import dtimer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  dt_ctl_t      ctl_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;

  assign wrap_o = ctl_i.inc && !ctl_i.clr && (cnt_o == TOP);

  always_ff @(posedge clk_i) begin
    if (rst_i || ctl_i.clr) cnt_o <= '0;
    else if (ctl_i.inc)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dual_timer_cascade.sv
module dual_timer_cascade
  import dtimer_pkg::*;
#(
  parameter int unsigned BYTE_W = DT_BYTE_W,
  parameter int unsigned SEL_W  = DT_SEL_W,
  parameter int unsigned NSRC   = DT_NSRC
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NSRC-1:0]     strobes_i,
  input  logic [SEL_W-1:0]    clk_sel_i,
  input  logic                enable_i,
  input  logic                cascade_i,
  input  logic                cmp_lo_we_i,
  input  logic                cmp_hi_we_i,
  input  logic [BYTE_W-1:0]   cmp_wdata_i,
  output logic                irq_lo_o,
  output logic                irq_hi_o,
  output logic                tog_lo_o,
  output logic [2*BYTE_W-1:0] count_o
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic              tick, en_q, start, run;
  logic              lo_hit, hi_hit, full_hit, lo_wrap, hi_wrap_unused;
  logic [BYTE_W-1:0] cmp_lo, cmp_hi, cnt_lo, cnt_hi;
  dt_ctl_t           ctl_lo, ctl_hi;

  dtimer_tick_sel #(.SEL_W(SEL_W), .NSRC(NSRC)) u_tick (
    .strobes_i(strobes_i), .sel_i(clk_sel_i), .tick_o(tick)
  );

  dtimer_cmp_reg #(.W(BYTE_W)) u_cmp_lo (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(cmp_lo_we_i),
    .wdata_i(cmp_wdata_i), .q_o(cmp_lo)
  );
  dtimer_cmp_reg #(.W(BYTE_W)) u_cmp_hi (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(cmp_hi_we_i),
    .wdata_i(cmp_wdata_i), .q_o(cmp_hi)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) en_q <= 1'b0;
    else       en_q <= enable_i;
  end

  assign start    = enable_i && !en_q;
  assign run      = enable_i && en_q && tick;
  assign lo_hit   = (cnt_lo == cmp_lo);
  assign hi_hit   = (cnt_hi == cmp_hi);
  assign full_hit = lo_hit && hi_hit;

  always_comb begin
    ctl_lo.clr = start || (run && (cascade_i ? full_hit : lo_hit));
    ctl_lo.inc = run;
    ctl_hi.clr = start || (run && (cascade_i ? full_hit : hi_hit));
    ctl_hi.inc = cascade_i ? lo_wrap : run;
  end

  dtimer_chan #(.W(BYTE_W)) u_lo (
    .clk_i(clk_i), .rst_i(rst_i), .ctl_i(ctl_lo), .cnt_o(cnt_lo), .wrap_o(lo_wrap)
  );
  dtimer_chan #(.W(BYTE_W)) u_hi (
    .clk_i(clk_i), .rst_i(rst_i), .ctl_i(ctl_hi), .cnt_o(cnt_hi), .wrap_o(hi_wrap_unused)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_lo_o <= 1'b0;
      irq_hi_o <= 1'b0;
      tog_lo_o <= 1'b0;
    end else begin
      irq_lo_o <= run && lo_hit;
      irq_hi_o <= run && (cascade_i ? full_hit : hi_hit);
      if (run && lo_hit) tog_lo_o <= !tog_lo_o;
    end
  end

  assign count_o = {cnt_hi, cnt_lo};

  // R3: counting frozen while disabled
  a_r3_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !enable_i |=> ($stable(count_o) && !irq_lo_o && !irq_hi_o));

  // R2: an out-of-range select gives no tick
  a_r2_bad_sel_stable: assert property (@(posedge clk_i) disable iff (rst_i)
    (clk_sel_i >= SEL_W'(NSRC) && enable_i && en_q) |=> $stable(count_o));

  // R7: restart clears the counters
  a_r7_start_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    (enable_i && !en_q) |=> (count_o == CNT_W'(0)));

  // R5: a 16-bit terminal pulse leaves the counter at zero
  a_r5_clear_on_full: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_hi_o && $past(cascade_i)) |-> (count_o == CNT_W'(0)));

  // R6: the toggle output flips exactly with the low pulse
  a_r6_tog_flips: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_lo_o |-> (tog_lo_o != $past(tog_lo_o)));
  a_r6_tog_steady: assert property (@(posedge clk_i) disable iff (rst_i)
    !irq_lo_o |-> $stable(tog_lo_o));
endmodule

// File: tb/dual_timer_cascade_tb.sv
module dual_timer_cascade_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  strobes = '0;
  logic [3:0]  sel = '0;
  logic        en = 1'b0, casc = 1'b0, we_lo = 1'b0, we_hi = 1'b0;
  logic [7:0]  wdata = '0;
  logic        irq_lo, irq_hi, tog;
  logic [15:0] cnt;

  int tests = 0, fails = 0, pc = 0;
  bit checking = 0, done = 0;

  // reference model state
  int m_lo = 0, m_hi = 0, m_clo = 0, m_chi = 0, m_irql = 0, m_irqh = 0, m_tog = 0, m_enq = 0;

  always #4 clk = ~clk;

  dual_timer_cascade u_dut (
    .clk_i(clk), .rst_i(rst), .strobes_i(strobes), .clk_sel_i(sel),
    .enable_i(en), .cascade_i(casc), .cmp_lo_we_i(we_lo), .cmp_hi_we_i(we_hi),
    .cmp_wdata_i(wdata), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi), .tog_lo_o(tog),
    .count_o(cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // prescaled strobes: bit k divides by 2^(k+1)
  always @(negedge clk) begin
    pc++;
    for (int k = 0; k < 5; k++) strobes[k] = ((pc % (2 << k)) == 0);
  end

  always @(posedge clk) begin
    int tk, c, n;
    if (rst) begin
      m_lo = 0; m_hi = 0; m_clo = 0; m_chi = 0;
      m_irql = 0; m_irqh = 0; m_tog = 0; m_enq = 0;
    end else begin
      tk = (sel < 5) ? int'(strobes[sel[2:0]]) : 0;
      m_irql = 0; m_irqh = 0;
      if (en && !m_enq) begin
        m_lo = 0; m_hi = 0;
      end else if (en && tk == 1) begin
        if (m_lo == m_clo) begin m_irql = 1; m_tog = 1 - m_tog; end
        if (casc) begin
          c = m_hi * 256 + m_lo; n = m_chi * 256 + m_clo;
          if (c == n) begin c = 0; m_irqh = 1; end
          else c = (c + 1) % 65536;
          m_hi = c / 256; m_lo = c % 256;
        end else begin
          if (m_hi == m_chi) begin m_hi = 0; m_irqh = 1; end
          else m_hi = (m_hi + 1) % 256;
          if (m_lo == m_clo) m_lo = 0;
          else m_lo = (m_lo + 1) % 256;
        end
      end
      m_enq = int'(en);
      if (we_lo) m_clo = int'(wdata);
      if (we_hi) m_chi = int'(wdata);
    end
  end

  // compare against the model every cycle
  always @(negedge clk) begin
    if (checking && !rst) begin
      chk(casc ? "R4 count" : "R8 count", int'(cnt), m_hi * 256 + m_lo);
      chk("R5/R8 irq_hi", int'(irq_hi), m_irqh);
      chk("R6 irq_lo", int'(irq_lo), m_irql);
      chk("R6 tog", int'(tog), m_tog);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmp(input int v);
    wdata = v[7:0]; we_lo = 1'b1; cyc(1);
    wdata = v[15:8]; we_lo = 1'b0; we_hi = 1'b1; cyc(1);
    we_hi = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t0, t1, snap;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 count", int'(cnt), 0);
    chk("R1 irq", int'({irq_lo, irq_hi, tog}), 0);
    checking = 1;

    // cascade, N = 3, divide-by-2: pulse every 4 ticks = 8 cycles (R5)
    casc = 1'b1; sel = 4'd0; wr_cmp(16'h0003);
    en = 1'b1;
    cyc(20);
    while (!irq_hi) cyc(1);
    t0 = pc; cyc(1);
    while (!irq_hi) cyc(1);
    t1 = pc;
    chk("R5 period cycles", t1 - t0, 8);
    cyc(30);

    // N = 0x0102: forces low wrap into high (R4)
    wr_cmp(16'h0102);
    cyc(1200);

    // slow strobe (R2)
    sel = 4'd4; wr_cmp(16'h0005);
    cyc(500);
    sel = 4'd2; cyc(200);

    // invalid select freezes the count (R2), compare write does not clear it (R9)
    sel = 4'd7; cyc(2);
    snap = int'(cnt);
    cyc(100);
    chk("R2 bad select hold", int'(cnt), snap);
    wdata = 8'h00; we_lo = 1'b1; cyc(1); we_lo = 1'b0; cyc(1);
    chk("R9 write no clear", int'(cnt), snap);

    // enable low holds (R3)
    sel = 4'd0; cyc(7);
    en = 1'b0; cyc(1);
    snap = int'(cnt);
    cyc(50);
    chk("R3 hold count", int'(cnt), snap);
    chk("R3 no irq", int'({irq_lo, irq_hi}), 0);

    // restart clears (R7)
    wr_cmp(16'h0040);
    en = 1'b1; cyc(1);
    chk("R7 restart clear", int'(cnt), 0);
    cyc(300);

    // N = 0: terminal every tick
    wr_cmp(16'h0000); cyc(40);

    // independent mode (R8)
    casc = 1'b0; wr_cmp(16'h0205); cyc(200);
    sel = 4'd1; wr_cmp(16'h0907); cyc(300);

    // back to cascade with a wrap (R10 via per-cycle word compare)
    casc = 1'b1; sel = 4'd0; wr_cmp(16'h0201); cyc(1400);

    checking = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule